// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block sits between a host processor's memory strobes and a battery-backed static RAM. A comparator outside the block reports whether the supply is inside tolerance. While the supply is bad, the block holds the memory's chip-enable and write-enable inactive and drives the processor reset low. Nothing the host does can reach the memory in that state.

When the supply recovers, two independent timers start from the same moment. The shorter timer ends write protection. The longer timer releases the open-drain processor reset. A new supply failure during either recovery interval clears both timers at once and re-blocks the strobes. The block also forwards the comparator's tolerance select, which chooses a trip point 5% or 10% below a 5 V nominal supply.

All delays are parameters in microseconds. They are converted to clock cycles from a clock-frequency parameter in MHz. Elaboration rejects a configuration whose failure response cannot meet 1.5 µs for the strobes and 3 µs for reset.

Top module: `pfail_guard`

## Requirements
- R1: While rst_ni is low, and afterwards until a valid supply has been seen, mem_ce_no and mem_we_no are 1 and cpu_rst_no is driven 0.
- R2: supply_ok_i passes through a two-stage synchronizer. A change sampled on one rising edge has no effect on the outputs after that edge, and takes effect after the second edge.
- R3: When supply_ok_i falls, the memory strobes are forced to 1 and cpu_rst_no to 0 after the second rising edge. This is within 1.5 µs and 3 µs at the configured clock.
- R4: With WP_CYC = CLK_MHZ*WP_REC_US, write protection lifts after rising edge WP_CYC+3, counted from the first edge that samples supply_ok_i high, provided host_ce_ni is 1 at that edge.
- R5: If host_ce_ni is 0 when the write-protect timer expires, protection stays in place. It lifts after the first rising edge that samples host_ce_ni at 1, so no partial access reaches the memory.
- R6: When unprotected, mem_ce_no equals host_ce_ni and mem_we_no equals host_we_ni in the same cycle.
- R7: When protected, mem_ce_no and mem_we_no stay 1 whatever the host strobes do.
- R8: With RST_CYC = CLK_MHZ*RST_REC_US, cpu_rst_no is released after rising edge RST_CYC+2, counted from the first edge that samples supply_ok_i high. It is never released before write protection has expired.
- R9: cpu_rst_no is open-drain. It is either driven 0 or left high-impedance, and reads 1 only through an external pull-up.
- R10: A supply failure while either recovery timer runs restarts both timers. The full WP_CYC+3 and RST_CYC+2 delays then apply from the next rise.
- R11: tol_sel_o always equals tol_sel_i, with no clocking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply-in-tolerance flag from the external comparator, asynchronous |
| tol_sel_i | input | 1 | Trip-point select: 0 = 5% below nominal, 1 = 10% below |
| tol_sel_o | output | 1 | Tolerance select forwarded to the comparator |
| host_ce_ni | input | 1 | Host chip-enable, active low |
| host_we_ni | input | 1 | Host write-enable, active low |
| mem_ce_no | output | 1 | Gated chip-enable to the memory, active low |
| mem_we_no | output | 1 | Gated write-enable to the memory, active low |
| cpu_rst_no | output | 1 | Open-drain processor reset, active low |

## Verification
Two events can land in the same cycle: the write-protect timer expiring and the host holding an access open. The bench provokes this by keeping host_ce_ni low through expiry and then raising it. It expects protection to hold until the edge that samples the idle host, and to lift right after that edge.

A second coincidence is a supply failure while one timer has expired and the other is still counting. The bench judges this by re-measuring both recovery delays in cycles after the next rise and requiring the full values. Throughout, any write strobe that reaches the memory during a protected window is counted as a failure.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned N_TIMERS    = 2;
  localparam int unsigned TMR_WP      = 0;
  localparam int unsigned TMR_RST     = 1;

  function automatic int unsigned us_to_cyc(input int unsigned mhz, input int unsigned us);
    return mhz * us;
  endfunction
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  // resets to 0: supply treated as bad until proven good
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pfg_timer.sv
module pfg_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIM);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM); // R4
  AST_DONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !done_o); // R10
endmodule

// File: rtl/pfg_gate.sv
module pfg_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ok_i,
  input  logic wp_done_i,
  input  logic rst_done_i,
  input  logic host_ce_ni,
  input  logic host_we_ni,
  output logic mem_ce_no,
  output logic mem_we_no,
  output logic rst_hold_o
);
  logic prot_q;
  logic prot;

  // release only on an idle host cycle; set again on any failure
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      prot_q <= 1'b1;
    else if (!ok_i)                   prot_q <= 1'b1;
    else if (wp_done_i && host_ce_ni) prot_q <= 1'b0;
  end

  // failure bypasses the register for the fastest block
  assign prot       = prot_q | ~ok_i;
  assign mem_ce_no  = prot | host_ce_ni;
  assign mem_we_no  = prot | host_we_ni;
  assign rst_hold_o = ~ok_i | ~rst_done_i;

  AST_NO_HALF_LIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prot_q) |-> $past(host_ce_ni)); // R5
  AST_LIFT_NEEDS_TIMER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prot_q) |-> $past(wp_done_i)); // R4
endmodule

// File: rtl/pfail_guard.sv
module pfail_guard #(
  parameter int unsigned CLK_MHZ    = 200,
  parameter int unsigned WP_REC_US  = 125000,
  parameter int unsigned RST_REC_US = 350000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic tol_sel_i,
  output logic tol_sel_o,
  input  logic host_ce_ni,
  input  logic host_we_ni,
  output logic mem_ce_no,
  output logic mem_we_no,
  output logic cpu_rst_no
);
  import pfg_pkg::*;

  localparam int unsigned WP_CYC   = us_to_cyc(CLK_MHZ, WP_REC_US);
  localparam int unsigned RST_CYC  = us_to_cyc(CLK_MHZ, RST_REC_US);
  localparam int unsigned GATE_DL  = (CLK_MHZ * 3) / 2; // 1.5 us
  localparam int unsigned RST_DL   = CLK_MHZ * 3;       // 3 us
  localparam int unsigned TLIM [N_TIMERS] = '{WP_CYC, RST_CYC};

  if (SYNC_STAGES > GATE_DL || SYNC_STAGES > RST_DL) begin : g_bad_dl
    $error("failure response exceeds deadline at this clock");
  end
  if (RST_CYC <= WP_CYC) begin : g_bad_order
    $error("reset recovery must exceed write-protect recovery");
  end

  logic                ok_sync;
  logic [N_TIMERS-1:0] tmr_done;
  logic                rst_hold;

  assign tol_sel_o = tol_sel_i; // R11

  pfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (supply_ok_i),
    .q_o   (ok_sync)
  );

  for (genvar gi = 0; gi < N_TIMERS; gi++) begin : g_tmr
    pfg_timer #(.LIMIT(TLIM[gi])) u_tmr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (ok_sync),
      .done_o(tmr_done[gi])
    );
  end

  pfg_gate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ok_i      (ok_sync),
    .wp_done_i (tmr_done[TMR_WP]),
    .rst_done_i(tmr_done[TMR_RST]),
    .host_ce_ni(host_ce_ni),
    .host_we_ni(host_we_ni),
    .mem_ce_no (mem_ce_no),
    .mem_we_no (mem_we_no),
    .rst_hold_o(rst_hold)
  );

  // R9: open drain, low or released
  assign cpu_rst_no = rst_hold ? 1'b0 : 1'bz;

  AST_FAIL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!supply_ok_i && $past(!supply_ok_i)) |=> (mem_ce_no && mem_we_no && rst_hold)); // R3
  AST_RST_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_done[TMR_RST] |-> tmr_done[TMR_WP]); // R8
endmodule

// File: tb/pfail_guard_tb.sv
`timescale 1ns/1ps
module pfail_guard_tb;
  localparam int unsigned CLK_MHZ    = 200;
  localparam int unsigned WP_REC_US  = 5;
  localparam int unsigned RST_REC_US = 12;
  localparam int WP_EXP  = CLK_MHZ * WP_REC_US + 3;
  localparam int RST_EXP = CLK_MHZ * RST_REC_US + 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic supply_ok = 1'b0;
  logic tol_i = 1'b0;
  logic host_ce_n = 1'b1;
  logic host_we_n = 1'b1;
  logic tol_o, mem_ce_n, mem_we_n;
  wire  cpu_rst_n;
  int   checks = 0;
  int   fails  = 0;

  pullup (cpu_rst_n);

  always #2.5 clk = ~clk;

  pfail_guard #(.CLK_MHZ(CLK_MHZ), .WP_REC_US(WP_REC_US), .RST_REC_US(RST_REC_US)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .tol_sel_i(tol_i),
    .tol_sel_o(tol_o), .host_ce_ni(host_ce_n), .host_we_ni(host_we_n),
    .mem_ce_no(mem_ce_n), .mem_we_no(mem_we_n), .cpu_rst_no(cpu_rst_n)
  );

  function automatic logic exp_strobe(input logic prot, input logic h);
    return prot ? 1'b1 : h;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // raise supply, count edges to protection lift and reset release
  task automatic measure(input string tag);
    int wp_n = 0;
    int rs_n = 0;
    int leak = 0;
    host_ce_n = 1'b1;
    host_we_n = 1'b0;
    supply_ok = 1'b1;
    for (int n = 1; n <= RST_EXP + 10; n++) begin
      step(1);
      if (wp_n == 0 && mem_we_n == 1'b0) wp_n = n;
      if (rs_n == 0 && cpu_rst_n === 1'b1) rs_n = n;
      if (rs_n != 0 && wp_n == 0) leak++;
    end
    chk(wp_n == WP_EXP, {"R4 lift edge ", tag}, wp_n, WP_EXP);
    chk(rs_n == RST_EXP, {"R8 reset release edge ", tag}, rs_n, RST_EXP);
    chk(leak == 0, {"R8 reset before lift ", tag}, leak, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=hang expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0071));
    // R1: reset state, host strobes active
    host_ce_n = 1'b0;
    host_we_n = 1'b0;
    step(3);
    chk(mem_ce_n == 1'b1 && mem_we_n == 1'b1, "R1 strobes in reset", {mem_ce_n, mem_we_n}, 3);
    chk(cpu_rst_n === 1'b0, "R1 reset driven low", cpu_rst_n, 0);
    rst_ni = 1'b1;
    step(10);
    chk(mem_we_n == 1'b1 && mem_ce_n == 1'b1, "R1 strobes before valid supply", {mem_ce_n, mem_we_n}, 3);
    chk(cpu_rst_n === 1'b0, "R1 reset before valid supply", cpu_rst_n, 0);

    measure("first");
    chk(cpu_rst_n === 1'b1, "R9 released reads pull-up", cpu_rst_n, 1);

    // R6 / R11: random traffic while unprotected
    begin
      int bad = 0;
      for (int i = 0; i < 200; i++) begin
        host_ce_n = 1'($urandom);
        host_we_n = 1'($urandom);
        tol_i     = 1'($urandom);
        #1;
        if (mem_ce_n != exp_strobe(1'b0, host_ce_n) || mem_we_n != exp_strobe(1'b0, host_we_n)) bad++;
        if (tol_o != tol_i) bad++;
        step(1);
      end
      chk(bad == 0, "R6 R11 pass-through mismatches", bad, 0);
    end

    // R2 / R3: failure with host mid-write
    host_ce_n = 1'b0;
    host_we_n = 1'b0;
    supply_ok = 1'b0;
    step(1);
    chk(mem_we_n == 1'b0, "R2 no effect after first edge", mem_we_n, 0);
    step(1);
    chk(mem_we_n == 1'b1 && mem_ce_n == 1'b1, "R3 strobes blocked", {mem_ce_n, mem_we_n}, 3);
    chk(cpu_rst_n === 1'b0, "R3 reset asserted", cpu_rst_n, 0);

    // R7: random traffic while protected
    begin
      int leak = 0;
      for (int i = 0; i < 150; i++) begin
        host_ce_n = 1'($urandom);
        host_we_n = 1'($urandom);
        #1;
        if (mem_we_n != exp_strobe(1'b1, host_we_n) || mem_ce_n != 1'b1) leak++;
        step(1);
      end
      chk(leak == 0, "R7 strobe leaked while protected", leak, 0);
    end

    // R10: failure while both timers run
    host_ce_n = 1'b1;
    host_we_n = 1'b0;
    supply_ok = 1'b1;
    step(WP_EXP - 200);
    chk(mem_we_n == 1'b1, "R4 still protected mid-recovery", mem_we_n, 1);
    supply_ok = 1'b0;
    step(3);
    measure("refail-both");

    // R10: failure after lift, reset timer still running
    supply_ok = 1'b0;
    step(3);
    supply_ok = 1'b1;
    step(WP_EXP + 50);
    chk(mem_we_n == 1'b0 && cpu_rst_n === 1'b0, "R8 lifted but reset held", {mem_we_n, cpu_rst_n}, 0);
    supply_ok = 1'b0;
    step(2);
    chk(mem_we_n == 1'b1, "R3 re-protect on late failure", mem_we_n, 1);
    step(1);
    measure("refail-rst");

    // R5: host access open across expiry
    supply_ok = 1'b0;
    step(3);
    host_ce_n = 1'b0;
    host_we_n = 1'b0;
    supply_ok = 1'b1;
    step(WP_EXP + 20);
    chk(mem_ce_n == 1'b1 && mem_we_n == 1'b1, "R5 held while host busy", {mem_ce_n, mem_we_n}, 3);
    host_ce_n = 1'b1;
    #1;
    chk(mem_we_n == 1'b1, "R5 not lifted before idle edge", mem_we_n, 1);
    step(1);
    chk(mem_we_n == 1'b0, "R5 lifted after idle edge", mem_we_n, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule